// File: doc/BRIEF.md
# Timing Event Slot Character Selector

This block produces the event-slot character for every cycle of a timing event stream. A downstream 8b10b encoder turns it into a line symbol. Each cycle the block chooses one of three outputs: a timing event code, the K28.5 comma that lets receivers align, or the reserved null data character. The output is an 8-bit character value with a flag that marks control (K) characters. The distributed-bus/data character that shares the same cycle is produced elsewhere.

Two sources can request an event. A beacon request always carries the reserved beacon code, and user logic presents an 8-bit code with a valid strobe. Commas lie on a fixed grid of every fourth slot. Any event due on a grid slot takes that slot, and the comma for that slot is skipped rather than delayed. When two requests meet in one cycle, the losing request waits in a single holding register and goes out in the next slot.

Top module: `evslot_mux`

## Requirements
- R1: The output is registered, so a request sampled at a rising clock edge appears on the output from that edge onward, one slot per clock cycle.
- R2: An accepted user event code appears as a data character, with `ch_byte` equal to the code and `ch_is_k` = 0. Accepted codes are 0x01 to 0xFF, excluding 0x7E.
- R3: A slot whose index is not a multiple of four and that has no event to carry outputs the null character: `ch_byte` = 0x00, `ch_is_k` = 0.
- R4: Slots are indexed from 0 at the first rising edge after reset is released. A slot whose index is a multiple of four and that has no event outputs the comma: `ch_byte` = 0xBC, `ch_is_k` = 1. `ch_is_k` is never 1 in any other slot.
- R5: An event due on a grid slot is sent in place of the comma. That comma is not moved to a later slot, and the next comma falls at the next multiple of four.
- R6: A beacon request is sent as data character 0x7E in the slot that samples it. The beacon wins over both a held request and a new user request.
- R7: A user request whose code is 0x7E or 0x00 is discarded. It produces no event and is not held.
- R8: A user request that loses to a beacon is held and sent in the next slot without a beacon. A held request goes out before a new user request, and the new request then takes the holding register.
- R9: A valid user request that arrives together with a beacon while the holding register is full is dropped. `ovf` then rises and stays at 1 until reset.
- R10: Reset is synchronous and active low. It clears the slot grid, the holding register and `ovf`, and sets the output to the null character (0x00, `ch_is_k` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bcn_req | input | 1 | Beacon event request for this slot |
| usr_vld | input | 1 | User event request strobe |
| usr_code | input | 8 | User event code |
| ch_byte | output | 8 | Event-slot character value |
| ch_is_k | output | 1 | Character is a control (K) character |
| ovf | output | 1 | Sticky flag: a user request was lost |

## Verification
The bench places events on grid slots. A design that defers the comma shows a K character off the grid, and one that lets the comma win loses the event. It pairs a beacon with a user request, then gives that held request a successor. A design with the wrong priority or a leaking holding register sends codes out of order, duplicates them or loses them. Reserved user codes must leave every following slot empty, and a beacon collision with a full holding register must raise `ovf` and keep it high without disturbing the code already held.

// File: rtl/evslot_pkg.sv
// Package: shared constants and character type for the event-slot selector.
// Assumes the Dx.y naming maps to the byte (y << 5) | x.
package evslot_pkg;

    // Character as handed to the line encoder
    typedef struct packed {
        logic       is_k;
        logic [7:0] val;
    } slot_char_t;

    // Build the byte value of character x.y
    function automatic logic [7:0] char_of(input int unsigned x, input int unsigned y);
        return 8'(((y & 7) << 5) | (x & 31));
    endfunction

    localparam logic [7:0] NULL_BYTE   = char_of(0, 0);   // D00.0
    localparam logic [7:0] COMMA_BYTE  = char_of(28, 5);  // K28.5
    localparam logic [7:0] BEACON_BYTE = char_of(30, 3);  // D30.3

endpackage

// File: rtl/evslot_phase.sv
// Module: slot grid counter.
// Counts slots modulo SYNC_PERIOD from reset; grid_slot is high when the
// slot being formed at the next edge sits on the comma grid.
module evslot_phase #(
    parameter int SYNC_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic grid_slot
);
    localparam int PHASE_W = (SYNC_PERIOD > 1) ? $clog2(SYNC_PERIOD) : 1;
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SYNC_PERIOD - 1);

    logic [PHASE_W-1:0] phase_q;

    // Advance the slot phase, wrapping at the grid period
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign grid_slot = (phase_q == '0);
endmodule

// File: rtl/evslot_arb.sv
// Module: event arbiter with one-entry holding register.
// Priority per slot: beacon, then held code, then new user code.
// Reserved user codes (null and beacon) are discarded on entry.
module evslot_arb #(
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] BEACON = CODE_W'(8'h7E)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcn_req,
    input  logic              usr_vld,
    input  logic [CODE_W-1:0] usr_code,
    output logic              ev_vld,
    output logic [CODE_W-1:0] ev_code,
    output logic              ovf
);
    logic              hold_full_q, hold_full_d;
    logic [CODE_W-1:0] hold_code_q, hold_code_d;
    logic              ovf_q, ovf_set;
    logic              usr_ok;

    // Screen out reserved user codes
    assign usr_ok = usr_vld && (usr_code != '0) && (usr_code != BEACON);

    // Pick this slot's event and next holding-register contents
    always_comb begin
        ev_vld      = 1'b0;
        ev_code     = '0;
        hold_full_d = hold_full_q;
        hold_code_d = hold_code_q;
        ovf_set     = 1'b0;
        if (bcn_req) begin
            ev_vld  = 1'b1;
            ev_code = BEACON;
            if (usr_ok) begin
                if (hold_full_q) ovf_set = 1'b1;
                else begin
                    hold_full_d = 1'b1;
                    hold_code_d = usr_code;
                end
            end
        end else if (hold_full_q) begin
            ev_vld      = 1'b1;
            ev_code     = hold_code_q;
            hold_full_d = usr_ok;
            if (usr_ok) hold_code_d = usr_code;
        end else if (usr_ok) begin
            ev_vld  = 1'b1;
            ev_code = usr_code;
        end
    end

    // Holding register and sticky overflow state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_code_q <= '0;
            ovf_q       <= 1'b0;
        end else begin
            hold_full_q <= hold_full_d;
            hold_code_q <= hold_code_d;
            ovf_q       <= ovf_q | ovf_set;
        end
    end

    assign ovf = ovf_q;
endmodule

// File: rtl/evslot_fmt.sv
// Module: output character register.
// Turns the chosen event, or its absence, into comma or null per grid.
module evslot_fmt
    import evslot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grid_slot,
    input  logic       ev_vld,
    input  logic [7:0] ev_code,
    output logic [7:0] ch_byte,
    output logic       ch_is_k
);
    slot_char_t nxt, cur_q;

    // Choose event, comma or null for this slot
    always_comb begin
        if (ev_vld)         nxt = '{is_k: 1'b0, val: ev_code};
        else if (grid_slot) nxt = '{is_k: 1'b1, val: COMMA_BYTE};
        else                nxt = '{is_k: 1'b0, val: NULL_BYTE};
    end

    // Register the character for the encoder
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{is_k: 1'b0, val: NULL_BYTE};
        else        cur_q <= nxt;
    end

    assign ch_byte = cur_q.val;
    assign ch_is_k = cur_q.is_k;
endmodule

// File: rtl/evslot_mux.sv
// Module: event-slot character selector (top).
// One character per clock; commas on a fixed grid, events override them.
module evslot_mux
    import evslot_pkg::*;
#(
    parameter int SYNC_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bcn_req,
    input  logic       usr_vld,
    input  logic [7:0] usr_code,
    output logic [7:0] ch_byte,
    output logic       ch_is_k,
    output logic       ovf
);
    logic       grid_slot;
    logic       ev_vld;
    logic [7:0] ev_code;

    evslot_phase #(.SYNC_PERIOD(SYNC_PERIOD)) u_phase (
        .clk(clk), .rst_n(rst_n), .grid_slot(grid_slot)
    );

    evslot_arb #(.CODE_W(8), .BEACON(BEACON_BYTE)) u_arb (
        .clk(clk), .rst_n(rst_n), .bcn_req(bcn_req), .usr_vld(usr_vld),
        .usr_code(usr_code), .ev_vld(ev_vld), .ev_code(ev_code), .ovf(ovf)
    );

    evslot_fmt u_fmt (
        .clk(clk), .rst_n(rst_n), .grid_slot(grid_slot), .ev_vld(ev_vld),
        .ev_code(ev_code), .ch_byte(ch_byte), .ch_is_k(ch_is_k)
    );
endmodule

// File: rtl/evslot_mux_chk.sv
// Module: property checker for evslot_mux, attached by bind.
// Keeps its own slot index so grid rules are checked against ports only.
module evslot_mux_chk #(
    parameter int SYNC_PERIOD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bcn_req,
    input logic [7:0] ch_byte,
    input logic       ch_is_k,
    input logic       ovf
);
    localparam int SW = (SYNC_PERIOD > 1) ? $clog2(SYNC_PERIOD) : 1;
    logic          seen_q;
    logic [SW-1:0] slot_q;

    // Track index (mod period) of the slot currently on the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            slot_q <= '0;
        end else if (!seen_q) begin
            seen_q <= 1'b1;
            slot_q <= '0;
        end else begin
            slot_q <= (slot_q == SW'(SYNC_PERIOD - 1)) ? '0 : slot_q + 1'b1;
        end
    end

    AST_K_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        ch_is_k |-> ch_byte == 8'hBC);  // R4
    AST_NO_K_OFF_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && slot_q != '0) |-> !ch_is_k);  // R5
    AST_GRID_NEVER_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && slot_q == '0) |-> (ch_is_k || ch_byte != 8'h00));  // R4
    AST_BEACON_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        bcn_req |=> (ch_byte == 8'h7E && !ch_is_k));  // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);  // R9
endmodule

bind evslot_mux evslot_mux_chk #(.SYNC_PERIOD(SYNC_PERIOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .bcn_req(bcn_req),
    .ch_byte(ch_byte), .ch_is_k(ch_is_k), .ovf(ovf)
);

// File: tb/evslot_mux_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, self-checking at the negedge.
module evslot_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bcn_req = 1'b0;
    logic       usr_vld = 1'b0;
    logic [7:0] usr_code = 8'h00;
    logic [7:0] ch_byte;
    logic       ch_is_k;
    logic       ovf;

    int vectors = 0;
    int fails = 0;
    int slot = 0;   // index of the next slot to be formed
    int cur = 0;    // index of the slot now on the output

    always #4 clk = ~clk;   // 125 MHz

    evslot_mux u_evslot_mux (
        .clk(clk), .rst_n(rst_n), .bcn_req(bcn_req), .usr_vld(usr_vld),
        .usr_code(usr_code), .ch_byte(ch_byte), .ch_is_k(ch_is_k), .ovf(ovf)
    );

    task automatic check(input string req, input logic [7:0] eb, input logic ek);
        vectors++;
        if (ch_byte !== eb || ch_is_k !== ek) begin
            fails++;
            $display("FAIL %s slot %0d: got %h k=%b, expected %h k=%b",
                     req, cur, ch_byte, ch_is_k, eb, ek);
        end
    endtask

    task automatic check_ovf(input string req, input logic e);
        vectors++;
        if (ovf !== e) begin
            fails++;
            $display("FAIL %s: ovf got %b, expected %b", req, ovf, e);
        end
    endtask

    // Drive one slot's inputs, let one edge pass, land on the next negedge
    task automatic tick(input logic b, input logic v, input logic [7:0] c);
        bcn_req = b; usr_vld = v; usr_code = c;
        @(negedge clk);
        cur = slot;
        slot++;
        bcn_req = 1'b0; usr_vld = 1'b0; usr_code = 8'h00;
    endtask

    function automatic logic [7:0] idle_b(input int s);
        return (s % 4 == 0) ? 8'hBC : 8'h00;
    endfunction
    function automatic logic idle_k(input int s);
        return (s % 4 == 0);
    endfunction

    task automatic idle_check(input string req);
        tick(1'b0, 1'b0, 8'h00);
        check(req, idle_b(cur), idle_k(cur));
    endtask

    // Run idle slots until the next slot has the given phase
    task automatic align(input int ph);
        while (slot % 4 != ph) idle_check("R3/R4 idle");
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 reset output", 8'h00, 1'b0);
        check_ovf("R10 reset ovf", 1'b0);
        rst_n = 1'b1;
        slot = 0;
    endtask

    task automatic t_idle;
        for (int i = 0; i < 9; i++) idle_check("R4 comma grid / R3 null");
    endtask

    task automatic t_user;
        align(1);
        tick(1'b0, 1'b1, 8'h10); check("R1 R2 code 0x10", 8'h10, 1'b0);
        tick(1'b0, 1'b1, 8'hFF); check("R2 code 0xFF", 8'hFF, 1'b0);
        tick(1'b0, 1'b1, 8'h01); check("R2 code 0x01", 8'h01, 1'b0);
        idle_check("R1 no repeat");
    endtask

    task automatic t_override;
        align(0);
        tick(1'b0, 1'b1, 8'h20); check("R5 event on grid", 8'h20, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0, 8'h00); check("R5 comma not deferred", 8'h00, 1'b0);
        end
        tick(1'b0, 1'b0, 8'h00); check("R5 next grid comma", 8'hBC, 1'b1);
        tick(1'b1, 1'b0, 8'h00); check("R6 beacon off grid", 8'h7E, 1'b0);
        align(0);
        tick(1'b1, 1'b0, 8'h00); check("R5 R6 beacon on grid", 8'h7E, 1'b0);
    endtask

    task automatic t_reject;
        align(1);
        tick(1'b0, 1'b1, 8'h7E); check("R7 beacon code rejected", 8'h00, 1'b0);
        tick(1'b0, 1'b0, 8'h00); check("R7 not held", 8'h00, 1'b0);
        tick(1'b0, 1'b1, 8'h00); check("R7 null code rejected", 8'h00, 1'b0);
        tick(1'b0, 1'b0, 8'h00); check("R7 grid comma after reject", 8'hBC, 1'b1);
    endtask

    task automatic t_refill;
        align(1);
        tick(1'b1, 1'b1, 8'h41); check("R6 beacon wins", 8'h7E, 1'b0);
        tick(1'b0, 1'b1, 8'h42); check("R8 held sent first", 8'h41, 1'b0);
        tick(1'b0, 1'b0, 8'h00); check("R8 new code follows", 8'h42, 1'b0);
        tick(1'b0, 1'b0, 8'h00); check("R8 holding empty", 8'hBC, 1'b1);
        check_ovf("R8 no overflow", 1'b0);
    endtask

    task automatic t_ovf;
        align(1);
        tick(1'b1, 1'b1, 8'h31); check("R9 beacon 1", 8'h7E, 1'b0);
        check_ovf("R9 no ovf yet", 1'b0);
        tick(1'b1, 1'b1, 8'h32); check("R9 beacon 2", 8'h7E, 1'b0);
        check_ovf("R9 ovf set", 1'b1);
        tick(1'b0, 1'b0, 8'h00); check("R9 held code kept", 8'h31, 1'b0);
        tick(1'b0, 1'b0, 8'h00); check("R9 dropped code absent", 8'hBC, 1'b1);
        for (int i = 0; i < 5; i++) idle_check("R9 idle");
        check_ovf("R9 ovf sticky", 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_idle();
        t_user();
        t_override();
        t_reject();
        t_refill();
        t_ovf();
        do_reset();
        idle_check("R10 grid restarts at 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule